// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address for 4 KB pages. It does this by walking a three-level translation tree held in memory. A request carries a virtual address. The walker then reads one descriptor from each level through a single-outstanding read port. The first descriptor comes from the root table named by `root_base`. The second comes from a pointer table. The last comes from a page table. The walker finishes with either the physical address or a fault code that names the level whose descriptor was invalid.

The virtual address is split unevenly into four fields:

| Bits | Field |
|------|-------|
| 31:25 | Root index (7 bits) |
| 24:18 | Pointer index (7 bits) |
| 17:12 | Page index (6 bits) |
| 11:0 | Byte offset |

Root and pointer tables hold 128 four-byte entries, which is 512 bytes each. Page tables hold 64 entries, which is 256 bytes. Every descriptor uses bits [1:0] as a type field, and the value 00 marks it invalid. A result is held on the outputs until the requester acknowledges it. A new request is taken only while the walker is idle.

Top module: `ptw3_walker`

## Requirements
- R1: After reset `resp_valid` and `mem_rd_req` are 0, `resp_fault` is 0 and `req_ready` is 1.
- R2: The first read address is `{root_base[31:9], vaddr[31:25], 2'b00}`.
- R3: The second read address is `{d1[31:9], vaddr[24:18], 2'b00}`, where d1 is the first descriptor read.
- R4: The third read address is `{d2[31:8], vaddr[17:12], 2'b00}`, where d2 is the second descriptor read.
- R5: When all three descriptors are valid, the result is `resp_paddr = {d3[31:12], vaddr[11:0]}` with `resp_fault = 0`, where d3 is the third descriptor read.
- R6: A descriptor whose bits [1:0] are 00 ends the walk with no further reads. `resp_fault` is then 1, 2 or 3 for the root, pointer or page level respectively, and `resp_paddr` is 0.
- R7: Each level issues exactly one single-cycle `mem_rd_req`. The walker advances only on `mem_rd_valid` that arrives at least one cycle after that request. A `mem_rd_valid` with no read outstanding is ignored.
- R8: A request is accepted only when `req_ready` is 1, which happens only in the idle state. `req_valid` during a walk or while a result is held has no effect.
- R9: `resp_valid`, `resp_paddr` and `resp_fault` stay stable until `resp_ack`. After the acknowledging edge the walker is idle, and a request presented in that same cycle is accepted no earlier than the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Root table base, 512-byte aligned |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request will be taken |
| mem_rd_req | output | 1 | Single-cycle descriptor read strobe |
| mem_rd_addr | output | 32 | Descriptor physical address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Descriptor read data |
| resp_valid | output | 1 | Result held |
| resp_paddr | output | 32 | Translated physical address (0 on fault) |
| resp_fault | output | 2 | 0 ok, 1/2/3 invalid at root/pointer/page level |
| resp_ack | input | 1 | Result consumed |

## Verification
The acknowledgement of a held result and the arrival of a fresh request can fall in the same cycle. The bench provokes this by raising `req_valid` with a new address on the very cycle it raises `resp_ack`. It then judges the outcome at the ports: one edge later the result must be gone and `req_ready` high, with the new request not yet consumed. One edge after that, `req_ready` must drop, and the second walk must read addresses derived from the new address. A stray `mem_rd_valid` injected while idle and while a result is held is likewise judged by unchanged outputs and correct later reads.

// File: rtl/ptw3_walker.sv
module ptw3_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] root_base,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  output logic        req_ready,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        resp_valid,
  output logic [31:0] resp_paddr,
  output logic [1:0]  resp_fault,
  input  logic        resp_ack
);

  typedef enum logic [2:0] {IDLE, L1_RD, L2_RD, L3_RD, DONE, FAULT} st_t;

  st_t         st;
  logic [31:0] va;
  logic [31:0] rd_addr;
  logic [31:0] paddr_q;
  logic [1:0]  fault_q;
  logic        issued;

  wire in_rd   = (st == L1_RD) || (st == L2_RD) || (st == L3_RD);
  wire got     = in_rd && issued && mem_rd_valid;
  wire bad     = (mem_rd_data[1:0] == 2'b00);

  assign req_ready   = (st == IDLE);
  assign mem_rd_req  = in_rd && !issued;
  assign mem_rd_addr = rd_addr;
  assign resp_valid  = (st == DONE) || (st == FAULT);
  assign resp_paddr  = paddr_q;
  assign resp_fault  = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      va      <= '0;
      rd_addr <= '0;
      paddr_q <= '0;
      fault_q <= '0;
      issued  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          va      <= req_vaddr;
          rd_addr <= {root_base[31:9], req_vaddr[31:25], 2'b00};
          paddr_q <= '0;
          fault_q <= '0;
          issued  <= 1'b0;
          st      <= L1_RD;
        end
        L1_RD, L2_RD, L3_RD: begin
          if (!issued) issued <= 1'b1;
          else if (got) begin
            issued <= 1'b0;
            if (bad) begin
              paddr_q <= '0;
              st      <= FAULT;
              case (st)
                L1_RD:   fault_q <= 2'd1;
                L2_RD:   fault_q <= 2'd2;
                default: fault_q <= 2'd3;
              endcase
            end else begin
              case (st)
                L1_RD: begin
                  rd_addr <= {mem_rd_data[31:9], va[24:18], 2'b00};
                  st      <= L2_RD;
                end
                L2_RD: begin
                  rd_addr <= {mem_rd_data[31:8], va[17:12], 2'b00};
                  st      <= L3_RD;
                end
                default: begin
                  paddr_q <= {mem_rd_data[31:12], va[11:0]};
                  st      <= DONE;
                end
              endcase
            end
          end
        end
        DONE, FAULT: if (resp_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ack |=> resp_valid && $stable(resp_paddr) && $stable(resp_fault));

  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ack |=> req_ready && !resp_valid);

  assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !resp_valid && !mem_rd_req);

  assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && (resp_fault != 2'd0) |-> resp_paddr == 32'd0);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid |=> !req_ready && mem_rd_req);

endmodule

// File: tb/ptw3_walker_tb.sv
module ptw3_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = 32'h0001_0000;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_fault;
  logic        resp_ack = 1'b0;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] rlog [0:7];
  int          nreads = 0;
  int          lat = 2;
  int          cnt = 0;
  logic [31:0] pend_a = '0;
  bit          spur = 1'b0;

  always #4 clk = ~clk;

  ptw3_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .resp_ack(resp_ack)
  );

  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (spur) begin
      mem_rd_valid = 1'b1;
      mem_rd_data  = 32'hFFFF_F003;
      spur = 1'b0;
    end
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem.exists(pend_a) ? mem[pend_a] : 32'h0;
      end
    end
    if (mem_rd_req) begin
      pend_a = mem_rd_addr;
      cnt = lat;
      if (nreads < 8) rlog[nreads] = mem_rd_addr;
      nreads++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] a1(logic [31:0] v);
    return {root_base[31:9], v[31:25], 2'b00};
  endfunction
  function automatic logic [31:0] a2(logic [31:0] d, logic [31:0] v);
    return {d[31:9], v[24:18], 2'b00};
  endfunction
  function automatic logic [31:0] a3(logic [31:0] d, logic [31:0] v);
    return {d[31:8], v[17:12], 2'b00};
  endfunction

  task automatic map(logic [31:0] v, logic [31:0] d1, logic [31:0] d2, logic [31:0] d3);
    mem[a1(v)] = d1;
    mem[a2(d1, v)] = d2;
    mem[a3(d2, v)] = d3;
  endtask

  task automatic start(logic [31:0] v);
    @(negedge clk);
    nreads = 0;
    req_valid = 1'b1; req_vaddr = v;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_resp();
    int n = 0;
    while (!resp_valid && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic ack();
    @(negedge clk); resp_ack = 1'b1;
    @(negedge clk); resp_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
    chk("R1 resp_fault", {30'd0, resp_fault}, 32'd0);
    chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_good(logic [31:0] v, logic [31:0] d1, logic [31:0] d2, logic [31:0] d3);
    map(v, d1, d2, d3);
    start(v);
    wait_resp();
    chk("R7 read count", nreads, 3);
    chk("R2 l1 addr", rlog[0], a1(v));
    chk("R3 l2 addr", rlog[1], a2(d1, v));
    chk("R4 l3 addr", rlog[2], a3(d2, v));
    chk("R5 paddr", resp_paddr, {d3[31:12], v[11:0]});
    chk("R5 fault", {30'd0, resp_fault}, 32'd0);
    ack();
  endtask

  task automatic t_fault(logic [31:0] v, int lvl);
    logic [31:0] d1 = 32'h0004_0201;
    logic [31:0] d2 = 32'h0008_0302;
    if (lvl == 1) mem[a1(v)] = 32'h0004_0200;
    else begin
      mem[a1(v)] = d1;
      if (lvl == 2) mem[a2(d1, v)] = 32'h0008_0300;
      else begin
        mem[a2(d1, v)] = d2;
        mem[a3(d2, v)] = 32'h1234_5000;
      end
    end
    start(v);
    wait_resp();
    repeat (4) @(negedge clk);
    chk("R6 fault code", {30'd0, resp_fault}, lvl);
    chk("R6 paddr zero", resp_paddr, 32'd0);
    chk("R6 reads stop", nreads, lvl);
    ack();
  endtask

  task automatic t_busy_req();
    logic [31:0] v = 32'h0A5C_3ABC, v2 = 32'hF000_0123;
    logic [31:0] d1 = 32'h0002_0001, d2 = 32'h0003_0101, d3 = 32'h7777_7003;
    map(v, d1, d2, d3);
    start(v);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v2;
    chk("R8 ready low in walk", {31'd0, req_ready}, 32'd0);
    wait_resp();
    repeat (3) @(negedge clk);
    chk("R8 ready low on hold", {31'd0, req_ready}, 32'd0);
    chk("R8 first result kept", resp_paddr, {d3[31:12], v[11:0]});
    chk("R9 hold valid", {31'd0, resp_valid}, 32'd1);
    req_valid = 1'b0;
    ack();
  endtask

  task automatic t_ack_collide();
    logic [31:0] v = 32'h2468_ACE0, v2 = 32'h1357_9BDF;
    logic [31:0] d1 = 32'h0005_0001, d2 = 32'h0006_0201, d3 = 32'hABCD_E001;
    map(v, d1, d2, d3);
    map(v2, d1, d2, 32'h5555_5002);
    start(v);
    wait_resp();
    @(negedge clk);
    resp_ack = 1'b1; req_valid = 1'b1; req_vaddr = v2;
    @(negedge clk);
    resp_ack = 1'b0;
    chk("R9 cleared after ack", {31'd0, resp_valid}, 32'd0);
    chk("R9 idle after ack", {31'd0, req_ready}, 32'd1);
    nreads = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 taken next edge", {31'd0, req_ready}, 32'd0);
    wait_resp();
    chk("R9 second walk l1", rlog[0], a1(v2));
    chk("R9 second paddr", resp_paddr, {20'h55555, v2[11:0]});
    ack();
  endtask

  task automatic t_spurious();
    logic [31:0] v = 32'h0000_0FFF;
    logic [31:0] d1 = 32'h0009_0003, d2 = 32'h000A_0001, d3 = 32'h0BAD_0001;
    @(negedge clk); spur = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 idle stray ignored", {31'd0, resp_valid}, 32'd0);
    map(v, d1, d2, d3);
    lat = 1;
    start(v);
    wait_resp();
    chk("R7 lat1 paddr", resp_paddr, {d3[31:12], v[11:0]});
    chk("R7 lat1 reads", nreads, 3);
    spur = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 held stray ignored", resp_paddr, {d3[31:12], v[11:0]});
    lat = 5;
    ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_good(32'h1234_5678, 32'h0002_0201, 32'h0003_0401, 32'hCAFE_B001);
    t_good(32'hFFFF_FFFF, 32'h0FF0_0E03, 32'h00C0_0F02, 32'h8000_1003);
    t_good(32'h0000_0000, 32'h0000_4001, 32'h0000_5101, 32'h0001_0001);
    t_fault(32'h4000_0000, 1);
    t_fault(32'h5555_5555, 2);
    t_fault(32'h6789_0123, 3);
    t_busy_req();
    t_ack_collide();
    t_spurious();
    t_good(32'h9ABC_DEF0, 32'h0031_0001, 32'h0032_0001, 32'h4444_4001);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule